// File: doc/BRIEF.md
# Tiled 2D View Address Generator

This block converts a pixel coordinate inside a two-dimensional tiled container into a linear address in a view space. The caller supplies a pixel format code, a three-bit orientation code and an (x, y) coordinate together with a valid strobe. One cycle later the block returns the view address, the row stride for that format, the slot width and height in pixels, and a flag that marks the coordinate as outside the container.

The format sets how many coordinate bits belong to each axis. A wider pixel gives up low-order bits on one or both axes, and the linear offset is shifted left by the number of bits given up, so every format fills the same offset field. The orientation code can mirror either axis within its valid range and can swap the roles of x and y. The offset is then packed with the orientation and the format into one address word.

The container and slot bit counts are elaboration parameters. The default container is 14 bits wide and 13 bits high, and the default slot is 6 by 6 bits.

Top module: `tiled_view_addr_gen`

## Requirements
- R1: While reset is held and after it is released, out_valid, out_of_range and addr are zero until a request is accepted.
- R2: A request with in_valid high in one cycle gives out_valid high in the next cycle with its results. In a cycle after in_valid was low, out_valid is low and addr, out_of_range, stride, slot_w and slot_h keep their values.
- R3: Format code 0 has shifts (0,0), code 1 has (0,1), code 2 has (1,1) and code 3 has (SW_BITS,SH_BITS), written as (x-shift, y-shift). The x axis has CW_BITS minus the x-shift bits and the y axis has CH_BITS minus the y-shift bits.
- R4: When x is greater than 2^xbits-1 or y is greater than 2^ybits-1, out_of_range is 1 and addr is all zero. Otherwise out_of_range is 0.
- R5: With orient bit 0 set, x is replaced by (2^xbits-1) - x before linearization.
- R6: With orient bit 1 set, y is replaced by (2^ybits-1) - y before linearization.
- R7: With orient bit 2 clear, the linear offset is (y << xbits) + x. With it set, the offset is (x << ybits) + y. Both use the coordinates after mirroring.
- R8: The linear offset is shifted left by x-shift + y-shift and placed in addr[CW_BITS+CH_BITS-1:0].
- R9: For an in-range request, addr[CW_BITS+CH_BITS+2 : CW_BITS+CH_BITS] holds the orientation code and the top two bits of addr hold the format code.
- R10: stride equals 1 << (CW_BITS + y-shift) of the request's format.
- R11: slot_w equals 1 << (SW_BITS - x-shift) and slot_h equals 1 << (SH_BITS - y-shift) of the request's format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| fmt | input | 2 | Pixel format code |
| orient | input | 3 | Bit 0 mirror x, bit 1 mirror y, bit 2 swap axes |
| x | input | COORD_W | Pixel column |
| y | input | COORD_W | Pixel row |
| out_valid | output | 1 | Results valid, one cycle after in_valid |
| addr | output | CW_BITS+CH_BITS+5 | View address {fmt, orient, offset} |
| out_of_range | output | 1 | Coordinate outside the format's axis range |
| stride | output | CW_BITS+SH_BITS+1 | Row stride of the format |
| slot_w | output | SW_BITS+1 | Slot width in pixels |
| slot_h | output | SH_BITS+1 | Slot height in pixels |

## Verification
The hardest condition to reach from the ports is the exact boundary of each axis range. A value is valid at the mask and rejected one above it, and the mask moves with the format. A value that is out of range for one format can be legal for another. The stimulus therefore pairs the largest legal coordinate with the smallest illegal one for every format. It also mirrors and swaps the extreme corners, where mirroring returns zero and the swapped offset uses every offset bit.

// File: rtl/tvag_pkg.sv
`timescale 1ns/1ps
package tvag_pkg;

  typedef enum logic [1:0] {
    FMT_B8   = 2'd0,
    FMT_B16  = 2'd1,
    FMT_B32  = 2'd2,
    FMT_PAGE = 2'd3
  } tv_fmt_e;

  localparam int ORI_W    = 3;
  localparam int FMT_W    = 2;
  localparam int ORI_MIRX = 0;
  localparam int ORI_MIRY = 1;
  localparam int ORI_SWAP = 2;

  // Low-order x bits a format gives up (part of its pixel size)
  function automatic int unsigned fmt_xshift(tv_fmt_e f, int unsigned slot_w_bits);
    case (f)
      FMT_B32:  return 1;
      FMT_PAGE: return slot_w_bits;
      default:  return 0;
    endcase
  endfunction

  // Low-order y bits a format gives up
  function automatic int unsigned fmt_yshift(tv_fmt_e f, int unsigned slot_h_bits);
    case (f)
      FMT_B16:  return 1;
      FMT_B32:  return 1;
      FMT_PAGE: return slot_h_bits;
      default:  return 0;
    endcase
  endfunction

endpackage

// File: rtl/tvag_geom.sv
`timescale 1ns/1ps
module tvag_geom
  import tvag_pkg::*;
#(
  parameter int CW_BITS  = 14,
  parameter int CH_BITS  = 13,
  parameter int SW_BITS  = 6,
  parameter int SH_BITS  = 6,
  parameter int SHW      = 6,
  parameter int STRIDE_W = 21,
  parameter int SLW_W    = 7,
  parameter int SLH_W    = 7
) (
  input  tv_fmt_e             fmt,
  output logic [SHW-1:0]      xbits,
  output logic [SHW-1:0]      ybits,
  output logic [SHW-1:0]      align,
  output logic [STRIDE_W-1:0] stride,
  output logic [SLW_W-1:0]    slot_w,
  output logic [SLH_W-1:0]    slot_h
);

  logic [SHW-1:0] xshift;
  logic [SHW-1:0] yshift;

  always_comb begin
    xshift = SHW'(fmt_xshift(fmt, SW_BITS));
    yshift = SHW'(fmt_yshift(fmt, SH_BITS));
    xbits  = SHW'(CW_BITS) - xshift;
    ybits  = SHW'(CH_BITS) - yshift;
    align  = xshift + yshift;
    stride = STRIDE_W'(1) << (SHW'(CW_BITS) + yshift);
    slot_w = SLW_W'(1) << (SHW'(SW_BITS) - xshift);
    slot_h = SLH_W'(1) << (SHW'(SH_BITS) - yshift);
  end

endmodule

// File: rtl/tvag_coord_xform.sv
`timescale 1ns/1ps
module tvag_coord_xform #(
  parameter int COORD_W = 16,
  parameter int SHW     = 6
) (
  input  logic [COORD_W-1:0] x_in,
  input  logic [COORD_W-1:0] y_in,
  input  logic [SHW-1:0]     xbits,
  input  logic [SHW-1:0]     ybits,
  input  logic               mir_x,
  input  logic               mir_y,
  output logic [COORD_W-1:0] x_out,
  output logic [COORD_W-1:0] y_out,
  output logic               out_of_range
);

  // All-ones mask of nbits; saturates to full width when nbits >= COORD_W
  function automatic logic [COORD_W-1:0] axis_mask(input logic [SHW-1:0] nbits);
    return (COORD_W'(1) << nbits) - COORD_W'(1);
  endfunction

  function automatic logic [COORD_W-1:0] reflect(input logic [COORD_W-1:0] c,
                                                 input logic [COORD_W-1:0] m,
                                                 input logic en);
    return en ? (m - c) : c;
  endfunction

  logic [COORD_W-1:0] xmask;
  logic [COORD_W-1:0] ymask;

  always_comb begin
    xmask        = axis_mask(xbits);
    ymask        = axis_mask(ybits);
    out_of_range = (x_in > xmask) || (y_in > ymask);
    x_out        = reflect(x_in, xmask, mir_x);
    y_out        = reflect(y_in, ymask, mir_y);
  end

endmodule

// File: rtl/tvag_offset_pack.sv
`timescale 1ns/1ps
module tvag_offset_pack #(
  parameter int COORD_W = 16,
  parameter int SHW     = 6,
  parameter int OFF_W   = 27,
  parameter int ORI_W   = 3,
  parameter int FMT_W   = 2,
  parameter int ADDR_W  = 32
) (
  input  logic [COORD_W-1:0] x_c,
  input  logic [COORD_W-1:0] y_c,
  input  logic [SHW-1:0]     xbits,
  input  logic [SHW-1:0]     ybits,
  input  logic [SHW-1:0]     align,
  input  logic               swap,
  input  logic [ORI_W-1:0]   orient,
  input  logic [FMT_W-1:0]   fmt,
  input  logic               out_of_range,
  output logic [ADDR_W-1:0]  addr
);

  function automatic logic [OFF_W-1:0] linearize(input logic [COORD_W-1:0] major,
                                                 input logic [COORD_W-1:0] minor,
                                                 input logic [SHW-1:0] minor_bits);
    return (OFF_W'(major) << minor_bits) + OFF_W'(minor);
  endfunction

  logic [OFF_W-1:0] lin;
  logic [OFF_W-1:0] offset;

  always_comb begin
    lin    = swap ? linearize(x_c, y_c, ybits) : linearize(y_c, x_c, xbits);
    offset = lin << align;
    addr   = out_of_range ? '0 : {fmt, orient, offset};
  end

endmodule

// File: rtl/tiled_view_addr_gen.sv
`timescale 1ns/1ps
module tiled_view_addr_gen
  import tvag_pkg::*;
#(
  parameter int CW_BITS  = 14,
  parameter int CH_BITS  = 13,
  parameter int SW_BITS  = 6,
  parameter int SH_BITS  = 6,
  parameter int COORD_W  = 16,
  localparam int OFF_W    = CW_BITS + CH_BITS,
  localparam int ADDR_W   = OFF_W + ORI_W + FMT_W,
  localparam int SHW      = $clog2(CW_BITS + CH_BITS + SW_BITS + SH_BITS + 1),
  localparam int STRIDE_W = CW_BITS + SH_BITS + 1,
  localparam int SLW_W    = SW_BITS + 1,
  localparam int SLH_W    = SH_BITS + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [1:0]          fmt,
  input  logic [2:0]          orient,
  input  logic [COORD_W-1:0]  x,
  input  logic [COORD_W-1:0]  y,
  output logic                out_valid,
  output logic [ADDR_W-1:0]   addr,
  output logic                out_of_range,
  output logic [STRIDE_W-1:0] stride,
  output logic [SLW_W-1:0]    slot_w,
  output logic [SLH_W-1:0]    slot_h
);

  // Named internal events, brought out for the assertions
  logic [SHW-1:0]      g_xbits;
  logic [SHW-1:0]      g_ybits;
  logic [SHW-1:0]      g_align;
  logic [STRIDE_W-1:0] g_stride;
  logic [SLW_W-1:0]    g_slot_w;
  logic [SLH_W-1:0]    g_slot_h;
  logic [COORD_W-1:0]  xf_x;
  logic [COORD_W-1:0]  xf_y;
  logic                xf_oor;
  logic [ADDR_W-1:0]   pk_addr;

  tvag_geom #(
    .CW_BITS(CW_BITS), .CH_BITS(CH_BITS), .SW_BITS(SW_BITS), .SH_BITS(SH_BITS),
    .SHW(SHW), .STRIDE_W(STRIDE_W), .SLW_W(SLW_W), .SLH_W(SLH_W)
  ) u_geom (
    .fmt    (tv_fmt_e'(fmt)),
    .xbits  (g_xbits),
    .ybits  (g_ybits),
    .align  (g_align),
    .stride (g_stride),
    .slot_w (g_slot_w),
    .slot_h (g_slot_h)
  );

  tvag_coord_xform #(
    .COORD_W(COORD_W), .SHW(SHW)
  ) u_xform (
    .x_in         (x),
    .y_in         (y),
    .xbits        (g_xbits),
    .ybits        (g_ybits),
    .mir_x        (orient[ORI_MIRX]),
    .mir_y        (orient[ORI_MIRY]),
    .x_out        (xf_x),
    .y_out        (xf_y),
    .out_of_range (xf_oor)
  );

  tvag_offset_pack #(
    .COORD_W(COORD_W), .SHW(SHW), .OFF_W(OFF_W),
    .ORI_W(ORI_W), .FMT_W(FMT_W), .ADDR_W(ADDR_W)
  ) u_pack (
    .x_c          (xf_x),
    .y_c          (xf_y),
    .xbits        (g_xbits),
    .ybits        (g_ybits),
    .align        (g_align),
    .swap         (orient[ORI_SWAP]),
    .orient       (orient),
    .fmt          (fmt),
    .out_of_range (xf_oor),
    .addr         (pk_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      addr         <= '0;
      out_of_range <= 1'b0;
      stride       <= '0;
      slot_w       <= '0;
      slot_h       <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        addr         <= pk_addr;
        out_of_range <= xf_oor;
        stride       <= g_stride;
        slot_w       <= g_slot_w;
        slot_h       <= g_slot_h;
      end
    end
  end

  // R2: one-cycle latency behind the strobe
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2: idle cycles keep the result
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(addr) && $stable(stride)));

  // R4: a rejected coordinate never leaks an address
  p_oor_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_of_range) |-> (addr == '0));

  // R5: mirrored/passed x stays inside its axis width when accepted
  p_x_in_axis_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !xf_oor) |-> ((xf_x >> g_xbits) == '0));

  // R6: same for y
  p_y_in_axis_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !xf_oor) |-> ((xf_y >> g_ybits) == '0));

  // R9: format field of the address follows the request
  p_fmt_field_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_of_range) |-> (addr[ADDR_W-1 -: FMT_W] == $past(fmt)));

  // R10: stride is a single power of two
  p_stride_pow2_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(stride) == 1));

endmodule

// File: tb/test_tiled_view_addr_gen.sv
`timescale 1ns/1ps
module test_tiled_view_addr_gen;

  localparam int CWB = 14;
  localparam int CHB = 13;
  localparam int SWB = 6;
  localparam int SHB = 6;
  localparam int CRD = 16;

  logic        clk;
  logic        rst_n;
  logic        vin;
  logic [1:0]  fmt_i;
  logic [2:0]  orient_i;
  logic [15:0] x_i;
  logic [15:0] y_i;
  logic        out_valid;
  logic [31:0] addr;
  logic        oor;
  logic [20:0] stride;
  logic [6:0]  slot_w;
  logic [6:0]  slot_h;

  int checks;
  int fails;

  tiled_view_addr_gen #(
    .CW_BITS(CWB), .CH_BITS(CHB), .SW_BITS(SWB), .SH_BITS(SHB), .COORD_W(CRD)
  ) i_tiled_view_addr_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(vin), .fmt(fmt_i), .orient(orient_i),
    .x(x_i), .y(y_i), .out_valid(out_valid), .addr(addr), .out_of_range(oor),
    .stride(stride), .slot_w(slot_w), .slot_h(slot_h)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Reference restated from the requirements
  function automatic void model(input int f, input int o, input int x, input int y,
                                output longint a, output int eo, output longint st,
                                output int sw, output int sh);
    int xs, ys, xb, yb, xm, ym, mx, my;
    longint lin;
    xs = (f == 2) ? 1 : (f == 3) ? SWB : 0;
    ys = (f == 0) ? 0 : (f == 3) ? SHB : 1;
    xb = CWB - xs;
    yb = CHB - ys;
    xm = (1 << xb) - 1;
    ym = (1 << yb) - 1;
    st = longint'(1) << (CWB + ys);
    sw = 1 << (SWB - xs);
    sh = 1 << (SHB - ys);
    eo = (x > xm || y > ym) ? 1 : 0;
    mx = ((o & 1) != 0) ? xm - x : x;
    my = ((o & 2) != 0) ? ym - y : y;
    if ((o & 4) != 0) lin = (longint'(mx) << yb) + longint'(my);
    else              lin = (longint'(my) << xb) + longint'(mx);
    if (eo != 0) a = 0;
    else a = (longint'(f) << (CWB + CHB + 3)) | (longint'(o) << (CWB + CHB)) | (lin << (xs + ys));
  endfunction

  task automatic run_one(input string tag, input int f, input int o, input int x, input int y);
    longint ea, est;
    int eo, esw, esh;
    model(f, o, x, y, ea, eo, est, esw, esh);
    @(negedge clk);
    fmt_i = 2'(f); orient_i = 3'(o); x_i = 16'(x); y_i = 16'(y); vin = 1'b1;
    @(negedge clk);
    vin = 1'b0;
    chk(tag, "out_valid", longint'(out_valid), 1);
    chk(tag, "out_of_range", longint'(oor), longint'(eo));
    chk(tag, "addr", longint'(addr), ea);
    chk(tag, "stride", longint'(stride), est);
    chk(tag, "slot_w", longint'(slot_w), longint'(esw));
    chk(tag, "slot_h", longint'(slot_h), longint'(esh));
  endtask

  task automatic t_reset_r1();
    chk("R1", "out_valid", longint'(out_valid), 0);
    chk("R1", "out_of_range", longint'(oor), 0);
    chk("R1", "addr", longint'(addr), 0);
  endtask

  task automatic t_plain_r3_r8();
    run_one("R3/R8", 0, 0, 5, 3);
    run_one("R3/R8", 1, 0, 1000, 200);
    run_one("R3/R8", 2, 0, 100, 7);
    run_one("R3/R8", 3, 0, 17, 9);
  endtask

  task automatic t_mirror_r5_r6();
    run_one("R5", 0, 1, 0, 0);
    run_one("R5", 2, 1, 8191, 12);
    run_one("R6", 1, 2, 3, 0);
    run_one("R6", 3, 2, 4, 127);
    run_one("R5/R6", 2, 3, 10, 20);
    run_one("R5/R6", 3, 3, 255, 127);
  endtask

  task automatic t_swap_r7();
    run_one("R7", 0, 4, 5, 3);
    run_one("R7", 2, 4, 8191, 4095);
    run_one("R7", 3, 7, 1, 2);
    run_one("R7", 1, 5, 77, 4000);
  endtask

  task automatic t_fields_r9();
    for (int o = 0; o < 8; o++) run_one("R9", 1, o, 33, 44);
  endtask

  task automatic t_range_r4();
    run_one("R4", 1, 0, 0, 4095);
    run_one("R4", 1, 0, 0, 4096);
    run_one("R4", 3, 0, 255, 0);
    run_one("R4", 3, 0, 256, 0);
    run_one("R4", 0, 0, 16383, 8191);
    run_one("R4", 0, 0, 16384, 0);
    run_one("R4", 2, 7, 0, 65535);
    run_one("R4", 2, 3, 8192, 0);
  endtask

  task automatic t_geom_r10_r11();
    for (int f = 0; f < 4; f++) run_one("R10/R11", f, 0, 1, 1);
  endtask

  task automatic t_hold_r2();
    logic [31:0] held_a;
    logic [20:0] held_s;
    run_one("R2", 2, 6, 300, 400);
    held_a = addr;
    held_s = stride;
    @(negedge clk);
    fmt_i = 2'd0; orient_i = 3'd0; x_i = 16'd9; y_i = 16'd9; vin = 1'b1;
    #1;
    chk("R2", "valid before edge", longint'(out_valid), 0);
    vin = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R2", "idle out_valid", longint'(out_valid), 0);
      chk("R2", "idle addr", longint'(addr), longint'(held_a));
      chk("R2", "idle stride", longint'(stride), longint'(held_s));
    end
  endtask

  task automatic t_sweep_r8();
    logic [15:0] lf;
    lf = 16'hACE1;
    for (int n = 0; n < 32; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      run_one("R8", n % 4, (n / 4) % 8, int'(lf >> (n % 3)), int'({lf[7:0], lf[15:8]} >> 3));
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    checks = 0; fails = 0;
    rst_n = 1'b0; vin = 1'b0; fmt_i = '0; orient_i = '0; x_i = '0; y_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset_r1();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r1();
    t_plain_r3_r8();
    t_mirror_r5_r6();
    t_swap_r7();
    t_fields_r9();
    t_range_r4();
    t_geom_r10_r11();
    t_hold_r2();
    t_sweep_r8();
    summary();
    $finish;
  end

endmodule